// File: doc/BRIEF.md
# Per-Bank DRAM Read Request Scheduler

This block is the request buffer and arbiter in front of a single DRAM bank. It holds a small set of pending read requests. Each request carries the row it needs, the application that issued it, and a sequence tag recording its arrival order. Whenever the bank command sequencer signals that it can take work, the scheduler hands over one buffered request and drops it from the buffer on that same clock edge.

Three policies are chosen at run time. The first serves strictly in arrival order. The second prefers requests that hit the row already open in the bank, and serves the oldest first among equals. The third applies an application priority rank first, then the row-hit-first rule, then age. The bank reports its open row as an input, so the scheduler's notion of a hit follows the bank as rows change.

One done flag per application goes high once none of that application's requests remain buffered. A stall-time monitor can time applications from this flag. The intended use is snapshot scheduling: the buffer is filled, then drained.

Top module: `bank_req_sched`

## Requirements
- R1: After reset the buffer is empty, `enq_ready` is 1, `grant_valid` is 0 and every bit of `app_done` is 1.
- R2: `enq_ready` is 0 while DEPTH requests are held. An enqueue attempted while it is 0 is dropped and is never granted.
- R3: `grant_valid` is 1 exactly when `bank_ready` is 1 and the buffer holds at least one request. An empty buffer never grants.
- R4: With `mode` = 2'b00, the grant is always the request with the smallest sequence tag, whatever its row.
- R5: With `mode` = 2'b01, a request whose row equals `open_row` is granted before any request that misses. Within the hit group, and within the miss group, the smallest sequence tag wins.
- R6: With `mode[1]` = 1, the grant comes from the application with the smallest rank value. Rank of application a is `app_rank[a*RANK_W +: RANK_W]`. Ties inside a rank level follow R5.
- R7: Several applications may hold the same rank value. Their requests then compete as one group under the R5 order, regardless of application ID.
- R8: A granted request is removed at the clock edge that ends its grant cycle. Each accepted request is granted exactly once.
- R9: `app_done[a]` is 1 exactly when no request of application a is buffered. It falls at the edge that accepts a request of a, and it rises at the edge that removes the last one.
- R10: An enqueue and a grant may happen in the same cycle. The grant is chosen among the requests already held, and the new request is kept and granted later.
- R11: Sequence tags increase by one per accepted request. The first request accepted into an empty buffer gets tag 0. `grant_seq` reports the tag of the granted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | A new request is offered |
| enq_ready | output | 1 | Buffer has a free slot |
| enq_row | input | ROW_W | Row index of the offered request |
| enq_app | input | APP_W | Application ID of the offered request |
| mode | input | 2 | 00 arrival order, 01 row-hit first, 1x ranked |
| app_rank | input | APP_N*RANK_W | Rank per application, lower value served first |
| open_row | input | ROW_W | Row currently open in the bank |
| bank_ready | input | 1 | Sequencer can accept a request this cycle |
| grant_valid | output | 1 | A request is handed over this cycle |
| grant_row | output | ROW_W | Row of the granted request |
| grant_app | output | APP_W | Application of the granted request |
| grant_seq | output | SEQ_W | Sequence tag of the granted request |
| app_done | output | APP_N | Per-application none-pending flag |

## Verification
Accepting a new request and granting a held one can happen in the same cycle. This is the case where the arbitration and the slot and tag bookkeeping touch the same state. The bench sets up this case with two requests buffered: it raises `bank_ready` and `enq_valid` at the same falling edge. It then checks that the grant that cycle is the oldest held request, and that the new request comes out last, carrying the next tag in sequence. It also checks that the done flags of all three applications track the buffer contents at every step.

// File: rtl/bank_req_sched.sv
module bank_req_sched #(
  parameter int DEPTH  = 8,
  parameter int ROW_W  = 8,
  parameter int APP_N  = 4,
  parameter int RANK_W = 2,
  parameter int SEQ_W  = 8,
  localparam int APP_W = (APP_N > 1) ? $clog2(APP_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_valid,
  output logic                    enq_ready,
  input  logic [ROW_W-1:0]        enq_row,
  input  logic [APP_W-1:0]        enq_app,
  input  logic [1:0]              mode,
  input  logic [APP_N*RANK_W-1:0] app_rank,
  input  logic [ROW_W-1:0]        open_row,
  input  logic                    bank_ready,
  output logic                    grant_valid,
  output logic [ROW_W-1:0]        grant_row,
  output logic [APP_W-1:0]        grant_app,
  output logic [SEQ_W-1:0]        grant_seq,
  output logic [APP_N-1:0]        app_done
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int KEY_W = RANK_W + 1 + SEQ_W;

  logic [DEPTH-1:0] vld;
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [APP_W-1:0] app_q [DEPTH];
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [SEQ_W-1:0] seq_ctr;
  logic [SEQ_W-1:0] new_tag;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] pick_idx;
  logic [KEY_W-1:0] pick_key;
  logic             pick_found;
  logic             enq_fire;

  assign enq_ready   = (cnt != CNT_W'(DEPTH));
  assign enq_fire    = enq_valid && enq_ready;
  assign grant_valid = bank_ready && (cnt != '0);
  assign new_tag     = (cnt == '0) ? '0 : seq_ctr;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    pick_idx   = '0;
    pick_key   = '1;
    pick_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [RANK_W-1:0] pr;
      logic              ms;
      logic [KEY_W-1:0]  k;
      pr = mode[1] ? app_rank[app_q[i]*RANK_W +: RANK_W] : '0;
      ms = (mode != 2'b00) && (row_q[i] != open_row);
      k  = {pr, ms, seq_q[i]};
      if (vld[i] && (!pick_found || (k < pick_key))) begin
        pick_found = 1'b1;
        pick_key   = k;
        pick_idx   = IDX_W'(i);
      end
    end
  end

  assign grant_row = row_q[pick_idx];
  assign grant_app = app_q[pick_idx];
  assign grant_seq = seq_q[pick_idx];

  always_comb begin
    for (int a = 0; a < APP_N; a++) begin
      app_done[a] = 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (vld[i] && (app_q[i] == APP_W'(a))) app_done[a] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= '0;
      cnt     <= '0;
      seq_ctr <= '0;
    end else begin
      if (grant_valid) vld[pick_idx] <= 1'b0;
      if (enq_fire) begin
        vld[free_idx] <= 1'b1;
        seq_ctr       <= new_tag + 1'b1;
      end
      cnt <= cnt + CNT_W'(enq_fire) - CNT_W'(grant_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      row_q[free_idx] <= enq_row;
      app_q[free_idx] <= enq_app;
      seq_q[free_idx] <= new_tag;
    end
  end
endmodule

module bank_req_sched_chk #(
  parameter int DEPTH = 8,
  parameter int APP_N = 4,
  parameter int SEQ_W = 8,
  localparam int APP_W = (APP_N > 1) ? $clog2(APP_N) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic [1:0]       mode,
  input logic             bank_ready,
  input logic             grant_valid,
  input logic [APP_W-1:0] grant_app,
  input logic [SEQ_W-1:0] grant_seq,
  input logic [APP_N-1:0] app_done,
  input logic [CNT_W-1:0] cnt
);
  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH)) |-> !enq_ready);

  assert_grant_has_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (bank_ready && (cnt != '0)));

  assert_grant_when_able_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ready && (cnt != '0)) |-> grant_valid);

  assert_grant_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !(enq_valid && enq_ready)) |=> (cnt == $past(cnt) - 1'b1));

  assert_age_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && (mode == 2'b00) && $past(grant_valid) && ($past(mode) == 2'b00))
      |-> (grant_seq > $past(grant_seq)));

  assert_owner_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !app_done[grant_app]);

  assert_empty_all_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (&app_done));
endmodule

bind bank_req_sched bank_req_sched_chk #(.DEPTH(DEPTH), .APP_N(APP_N), .SEQ_W(SEQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .mode(mode), .bank_ready(bank_ready), .grant_valid(grant_valid),
  .grant_app(grant_app), .grant_seq(grant_seq), .app_done(app_done), .cnt(cnt)
);

// File: tb/bank_req_sched_tb.sv
`timescale 1ns/1ps
module bank_req_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic       enq_ready;
  logic [7:0] enq_row = '0;
  logic [1:0] enq_app = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] app_rank = '0;
  logic [7:0] open_row = '0;
  logic       bank_ready = 1'b0;
  logic       grant_valid;
  logic [7:0] grant_row;
  logic [1:0] grant_app;
  logic [7:0] grant_seq;
  logic [3:0] app_done;

  int checks = 0;
  int errs = 0;
  bit timed_out = 1'b0;

  always #2 clk = ~clk;

  bank_req_sched dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_row(enq_row), .enq_app(enq_app), .mode(mode), .app_rank(app_rank),
    .open_row(open_row), .bank_ready(bank_ready), .grant_valid(grant_valid),
    .grant_row(grant_row), .grant_app(grant_app), .grant_seq(grant_seq),
    .app_done(app_done)
  );

  localparam int NS = 5;
  localparam int NR = 6;
  localparam logic [1:0] V_MODE [NS] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd3};
  localparam logic [7:0] V_OPEN [NS] = '{8'd3, 8'd3, 8'd3, 8'd3, 8'd6};
  localparam logic [7:0] V_RANK [NS] = '{8'h1B, 8'h1B, 8'h1B, 8'hC6, 8'h05};
  localparam int V_ROW [NS][NR] = '{'{5,3,9,3,12,3}, '{5,3,9,3,12,3},
                                   '{5,7,5,3,7,5},  '{3,4,3,8,4,3},  '{6,2,9,2,6,9}};
  localparam int V_APP [NS][NR] = '{'{0,1,2,0,1,2}, '{0,1,2,0,1,2},
                                   '{0,1,2,3,0,1},  '{0,1,2,1,2,0},  '{0,1,3,1,0,2}};
  localparam int V_EXP [NS][NR] = '{'{0,1,2,3,4,5}, '{1,3,5,0,2,4},
                                   '{3,0,2,5,1,4},  '{2,4,1,3,0,5},  '{2,5,0,4,1,3}};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic enq(input int r, input int a);
    @(negedge clk);
    enq_valid = 1'b1;
    enq_row   = 8'(r);
    enq_app   = 2'(a);
    @(posedge clk);
    #1 enq_valid = 1'b0;
  endtask

  task automatic run_tests();
    // R1: reset state
    @(negedge clk);
    bank_ready = 1'b1;
    #1;
    chk("R1", "enq_ready after reset", int'(enq_ready), 1);
    chk("R1", "grant_valid after reset", int'(grant_valid), 0);
    chk("R1", "app_done after reset", int'(app_done), 15);
    bank_ready = 1'b0;

    // R3/R9: held request, bank not ready
    enq(4, 1);
    @(negedge clk); #1;
    chk("R3", "no grant while bank busy", int'(grant_valid), 0);
    chk("R9", "app_done with app1 pending", int'(app_done), 4'b1101);

    // R10: enqueue and grant in one cycle
    enq(5, 0);
    @(negedge clk);
    mode = 2'b00; bank_ready = 1'b1;
    enq_valid = 1'b1; enq_row = 8'd7; enq_app = 2'd2;
    #1;
    chk("R10", "grant seq with concurrent enqueue", int'(grant_seq), 0);
    chk("R10", "grant row with concurrent enqueue", int'(grant_row), 4);
    @(posedge clk); #1 enq_valid = 1'b0;
    @(negedge clk); #1;
    chk("R10", "second grant seq", int'(grant_seq), 1);
    chk("R9", "app_done after app1 served", int'(app_done), 4'b1010);
    @(negedge clk); #1;
    chk("R10", "new request seq", int'(grant_seq), 2);
    chk("R10", "new request row", int'(grant_row), 7);
    chk("R10", "new request app", int'(grant_app), 2);
    @(negedge clk); #1;
    chk("R3", "no grant when empty", int'(grant_valid), 0);
    chk("R9", "all done after drain", int'(app_done), 15);
    bank_ready = 1'b0;

    // R2/R8/R11: fill, rejected enqueue, drain
    for (int i = 0; i < 8; i++) enq(10 + i, i % 4);
    @(negedge clk); #1;
    chk("R2", "enq_ready when full", int'(enq_ready), 0);
    enq(8'hEE, 3);
    @(negedge clk);
    bank_ready = 1'b1; mode = 2'b00;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk("R8", "drain grant valid", int'(grant_valid), 1);
      chk(k == 0 ? "R11" : "R8", "drain seq", int'(grant_seq), k);
      chk("R2", "drain row not rejected one", int'(grant_row), 10 + k);
    end
    @(negedge clk); #1;
    chk("R2", "nothing after eight grants", int'(grant_valid), 0);
    chk("R2", "enq_ready after drain", int'(enq_ready), 1);
    bank_ready = 1'b0;

    // R4..R7: table of policy scenarios
    for (int s = 0; s < NS; s++) begin
      bit pend [NR];
      int last_row;
      string req;
      req = (V_MODE[s] == 2'd0) ? "R4" : (V_MODE[s] == 2'd1) ? "R5" :
            (V_MODE[s] == 2'd2) ? "R6" : "R7";
      for (int j = 0; j < NR; j++) begin
        enq(V_ROW[s][j], V_APP[s][j]);
        pend[j] = 1'b1;
      end
      last_row = 0;
      @(negedge clk);
      mode = V_MODE[s]; app_rank = V_RANK[s]; open_row = V_OPEN[s];
      bank_ready = 1'b1;
      for (int k = 0; k < NR; k++) begin
        int e;
        logic [3:0] dexp;
        if (k > 0) begin
          @(negedge clk);
          open_row = 8'(last_row);
        end
        #1;
        e = V_EXP[s][k];
        dexp = 4'hF;
        for (int j = 0; j < NR; j++)
          if (pend[j]) dexp[V_APP[s][j]] = 1'b0;
        chk("R9", "app_done during drain", int'(app_done), int'(dexp));
        chk("R3", "grant present", int'(grant_valid), 1);
        chk(req, "grant seq", int'(grant_seq), e);
        chk(req, "grant row", int'(grant_row), V_ROW[s][e]);
        chk(req, "grant app", int'(grant_app), V_APP[s][e]);
        last_row = V_ROW[s][e];
        pend[e] = 1'b0;
      end
      @(negedge clk); #1;
      chk("R8", "scenario drained", int'(grant_valid), 0);
      chk("R9", "all done after scenario", int'(app_done), 15);
      bank_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule